// File: doc/BRIEF.md
# Dual-Role Global Interrupt Status Register

This block holds the top-level interrupt status word of a USB controller that can act as either host or device. Software reads one 32-bit status word over a simple register bus and clears the event flags in it by writing ones. The word mixes three kinds of bits:

- **Latched event flags.** Single-cycle pulses from the protocol engine set them.
- **Live condition flags.** These track FIFO state one cycle late.
- **Summary flags.** These are the OR of lower-level channel, endpoint, port and OTG sources. They fall only when their source is cleared.

The block also reports the current role in bit 0. It flags any bus access that lands in the register window of the role that is not active. Such an access still completes normally, and any write in it is discarded.

An interrupt line is raised when any visible status bit is enabled in a mask vector. Bits that have no meaning in the current role read as zero. Reserved positions always read as zero.

Top module: `dualrole_irq_status`

## Requirements
- R1: Stored state after reset is zero except bit 28 (connector ID change) and bit 26 (periodic TX FIFO empty), which come up set. With host role selected and the periodic FIFO inputs satisfied, the status word reads 0x1400_0001.
- R2: Bit 0 shows the role input: 1 for host, 0 for device. It is not writable.
- R3: Latched event flags are set one cycle after their pulse on `evt_i` at the same bit position. They stay set until software writes 1 to that position at `STS_ADDR`; a written 0 leaves them alone. The flags are bits 31, 30, 29, 28, 23, 22, 21, 20, 17, 14, 13, 12, 11, 10, 3 and 1.
- R4: When an event pulse and a write-1 clear hit the same latched bit in the same cycle, the bit ends up set.
- R5: Bits 21 (incomplete periodic) and 20 (incomplete isochronous IN) are set only in a cycle where `eopf_i` is also high.
- R6: Summary bits follow their sources in the same cycle, and writes do not affect them:
  - bit 25 is the OR of the host channel sources;
  - bit 24 is the port source;
  - bit 19 is the OR of the OUT endpoint sources;
  - bit 18 is the OR of the IN endpoint sources;
  - bit 2 is the OTG source.
- R7: Bit 4 follows `rx_nonempty_i` one cycle late and falls without any software write.
- R8: Bit 26 is set one cycle after two conditions both hold:
  - the free space meets the threshold: at least half of `PTX_DEPTH` when `ptx_full_sel_i` is 0, or exactly `PTX_DEPTH` when it is 1;
  - `pq_space_i` is nonzero.
- R9: Bit 1 is set one cycle after any access (read or write) to the host window while in device role, or to the device window while in host role. An access to `STS_ADDR` never sets it.
- R10: In device role, host-only bits 29, 26, 25 and 24 read as 0. In host role, device-only bits 23, 22, 20, 19, 18, 17, 14, 13, 12, 11, 10, 7 and 6 read as 0. Reserved bits 27, 16, 15, 9, 8 and 5 always read as 0.
- R11: Bit 7 (global OUT NAK in effect) and bit 6 (global IN NAK in effect) are set by their effect pulses and cleared by their clear inputs, one cycle late. Writing the status word does not clear them.
- R12: `irq_o` is high exactly when some visible status bit is also set in `irq_mask_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| host_mode_i | input | 1 | 1 = host role, 0 = device role |
| bus_sel_i | input | 1 | bus access valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | word address |
| bus_wdata_i | input | 32 | write data (ones clear latched flags) |
| bus_rdata_o | output | 32 | status word on a read of `STS_ADDR`, else 0 |
| evt_i | input | 32 | event pulses at status bit positions |
| eopf_i | input | 1 | end of periodic frame strobe |
| rx_nonempty_i | input | 1 | receive FIFO holds a packet |
| ptx_free_i | input | FREE_W | free words in periodic TX FIFO |
| ptx_full_sel_i | input | 1 | 1 = require fully empty, 0 = half empty |
| pq_space_i | input | PQ_W | free periodic request queue entries |
| hch_src_i | input | NCH | per-channel pending |
| port_src_i | input | 1 | host port pending |
| iep_src_i | input | NEP | IN endpoint pending |
| oep_src_i | input | NEP | OUT endpoint pending |
| otg_src_i | input | 1 | OTG event pending |
| nak_out_set_i | input | 1 | global OUT NAK took effect |
| nak_out_clr_i | input | 1 | global OUT NAK released |
| nak_in_set_i | input | 1 | global IN NAK took effect |
| nak_in_clr_i | input | 1 | global IN NAK released |
| irq_mask_i | input | 32 | per-bit interrupt enable |
| irq_o | output | 1 | masked interrupt request |

## Verification
The bench builds the block with 4 host channels, 3 endpoints, a 16-word periodic FIFO and narrow address windows (host 256..383, device 512..767, status at word 5). The small FIFO depth puts both threshold edges within reach: 7 versus 8 words for half empty, and 15 versus 16 for fully empty. The small source vectors let single channels and endpoints be toggled one at a time against the OR summaries. Addresses just inside each window exercise the role-mismatch flag in both roles.

// File: rtl/dri_pkg.sv
package dri_pkg;
   localparam int SW = 32;

   localparam logic [SW-1:0] HOST_ONLY = (32'h1 << 29) | (32'h1 << 26) | (32'h1 << 25) | (32'h1 << 24);
   localparam logic [SW-1:0] DEV_ONLY  = (32'h1 << 23) | (32'h1 << 22) | (32'h1 << 20) | (32'h1 << 19)
                                       | (32'h1 << 18) | (32'h1 << 17) | (32'h1 << 14) | (32'h1 << 13)
                                       | (32'h1 << 12) | (32'h1 << 11) | (32'h1 << 10) | (32'h1 << 7)
                                       | (32'h1 << 6);
   localparam logic [SW-1:0] RSV_BITS  = (32'h1 << 27) | (32'h1 << 16) | (32'h1 << 15) | (32'h1 << 9)
                                       | (32'h1 << 8) | (32'h1 << 5);
   // latched event positions (write-one-to-clear)
   localparam logic [SW-1:0] LATCH_BITS = (32'h1 << 31) | (32'h1 << 30) | (32'h1 << 29) | (32'h1 << 28)
                                        | (32'h1 << 23) | (32'h1 << 22) | (32'h1 << 21) | (32'h1 << 20)
                                        | (32'h1 << 17) | (32'h1 << 14) | (32'h1 << 13) | (32'h1 << 12)
                                        | (32'h1 << 11) | (32'h1 << 10) | (32'h1 << 3)  | (32'h1 << 1);
   localparam logic [SW-1:0] LATCH_RST  = (32'h1 << 28);
   localparam logic [SW-1:0] FRAME_GATED = (32'h1 << 21) | (32'h1 << 20);

   localparam int B_MISMATCH = 1;
   localparam int B_OTG      = 2;
   localparam int B_RXLVL    = 4;
   localparam int B_INNAK    = 6;
   localparam int B_OUTNAK   = 7;
   localparam int B_IEP      = 18;
   localparam int B_OEP      = 19;
   localparam int B_PORT     = 24;
   localparam int B_HCH      = 25;
   localparam int B_PTXE     = 26;
endpackage

// File: rtl/dri_latch_bank.sv
module dri_latch_bank
   import dri_pkg::*;
#(
   parameter logic [SW-1:0] KEEP_MASK = LATCH_BITS,
   parameter logic [SW-1:0] RST_VAL   = LATCH_RST
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] set_i,
   input  logic [SW-1:0] clr_i,
   output logic [SW-1:0] q_o
);
   if ((RST_VAL & ~KEEP_MASK) != '0) begin : g_bad_rst
      $error("reset value outside kept bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= ((q_o & ~clr_i) | set_i) & KEEP_MASK;
   end

   for (genvar i = 0; i < SW; i++) begin : g_chk
      if (KEEP_MASK[i]) begin : g_kept
         // R3: a latched flag holds until a one is written to it
         a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[i] && !clr_i[i]) |=> q_o[i]);
         // R4: a set in the same cycle as a clear leaves the flag set
         a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
      end
   end
endmodule

// File: rtl/dri_level_track.sv
module dri_level_track #(
   parameter int PTX_DEPTH = 1024,
   parameter int PQ_W      = 4,
   parameter int FREE_W    = $clog2(PTX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_nonempty_i,
   input  logic [FREE_W-1:0] ptx_free_i,
   input  logic              ptx_full_sel_i,
   input  logic [PQ_W-1:0]   pq_space_i,
   input  logic              nak_out_set_i,
   input  logic              nak_out_clr_i,
   input  logic              nak_in_set_i,
   input  logic              nak_in_clr_i,
   output logic              rx_lvl_o,
   output logic              ptx_empty_o,
   output logic              nak_out_o,
   output logic              nak_in_o
);
   localparam int HALF = PTX_DEPTH / 2;
   localparam logic [FREE_W-1:0] HALF_W = FREE_W'(HALF);
   localparam logic [FREE_W-1:0] FULL_W = FREE_W'(PTX_DEPTH);

   if (PTX_DEPTH < 2) begin : g_bad_depth
      $error("PTX_DEPTH must be at least 2");
   end
   if (PQ_W < 1) begin : g_bad_pq
      $error("PQ_W must be positive");
   end

   logic half_ok;
   // a power-of-two depth lets the half test use the upper bits only
   if ((PTX_DEPTH & (PTX_DEPTH - 1)) == 0) begin : g_half_pow2
      assign half_ok = (ptx_free_i >> $clog2(HALF)) != '0;
   end else begin : g_half_cmp
      assign half_ok = ptx_free_i >= HALF_W;
   end

   logic room_ok;
   assign room_ok = (ptx_full_sel_i ? (ptx_free_i == FULL_W) : half_ok) && (pq_space_i != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_lvl_o    <= 1'b0;
         ptx_empty_o <= 1'b1;
         nak_out_o   <= 1'b0;
         nak_in_o    <= 1'b0;
      end else begin
         rx_lvl_o    <= rx_nonempty_i;
         ptx_empty_o <= room_ok;
         nak_out_o   <= nak_out_set_i | (nak_out_o & ~nak_out_clr_i);
         nak_in_o    <= nak_in_set_i  | (nak_in_o  & ~nak_in_clr_i);
      end
   end

   // R7: the receive level flag tracks the FIFO one cycle late
   a_r7_rx_follow: assert property (@(posedge clk) disable iff (!rst_n)
      rx_nonempty_i |=> rx_lvl_o);
   // R11: an effective NAK flag persists until its clear input
   a_r11_nak_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (nak_out_o && !nak_out_clr_i) |=> nak_out_o);
endmodule

// File: rtl/dri_mode_guard.sv
module dri_mode_guard #(
   parameter int AW      = 10,
   parameter int STS_ADDR = 5,
   parameter int HOST_LO = 256,
   parameter int HOST_HI = 383,
   parameter int DEV_LO  = 512,
   parameter int DEV_HI  = 767
) (
   input  logic          host_mode_i,
   input  logic          sel_i,
   input  logic [AW-1:0] addr_i,
   output logic          mismatch_o
);
   if (HOST_LO > HOST_HI || DEV_LO > DEV_HI) begin : g_bad_win
      $error("empty address window");
   end
   if (!(HOST_HI < DEV_LO || DEV_HI < HOST_LO)) begin : g_overlap
      $error("host and device windows overlap");
   end
   if ((STS_ADDR >= HOST_LO && STS_ADDR <= HOST_HI) || (STS_ADDR >= DEV_LO && STS_ADDR <= DEV_HI)) begin : g_sts_in
      $error("status address inside a role window");
   end
   if (DEV_HI >= (1 << AW) || HOST_HI >= (1 << AW)) begin : g_aw
      $error("window beyond address width");
   end

   localparam logic [AW-1:0] H_LO = AW'(HOST_LO);
   localparam logic [AW-1:0] H_HI = AW'(HOST_HI);
   localparam logic [AW-1:0] D_LO = AW'(DEV_LO);
   localparam logic [AW-1:0] D_HI = AW'(DEV_HI);

   logic in_host, in_dev;
   assign in_host = (addr_i >= H_LO) && (addr_i <= H_HI);
   assign in_dev  = (addr_i >= D_LO) && (addr_i <= D_HI);
   assign mismatch_o = sel_i && (host_mode_i ? in_dev : in_host);
endmodule

// File: rtl/dualrole_irq_status.sv
module dualrole_irq_status
   import dri_pkg::*;
#(
   parameter int AW        = 10,
   parameter int STS_ADDR  = 5,
   parameter int HOST_LO   = 256,
   parameter int HOST_HI   = 383,
   parameter int DEV_LO    = 512,
   parameter int DEV_HI    = 767,
   parameter int NCH       = 16,
   parameter int NEP       = 16,
   parameter int PTX_DEPTH = 1024,
   parameter int PQ_W      = 4,
   parameter int FREE_W    = $clog2(PTX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_mode_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [AW-1:0]     bus_addr_i,
   input  logic [SW-1:0]     bus_wdata_i,
   output logic [SW-1:0]     bus_rdata_o,
   input  logic [SW-1:0]     evt_i,
   input  logic              eopf_i,
   input  logic              rx_nonempty_i,
   input  logic [FREE_W-1:0] ptx_free_i,
   input  logic              ptx_full_sel_i,
   input  logic [PQ_W-1:0]   pq_space_i,
   input  logic [NCH-1:0]    hch_src_i,
   input  logic              port_src_i,
   input  logic [NEP-1:0]    iep_src_i,
   input  logic [NEP-1:0]    oep_src_i,
   input  logic              otg_src_i,
   input  logic              nak_out_set_i,
   input  logic              nak_out_clr_i,
   input  logic              nak_in_set_i,
   input  logic              nak_in_clr_i,
   input  logic [SW-1:0]     irq_mask_i,
   output logic              irq_o
);
   localparam logic [AW-1:0] STS_A = AW'(STS_ADDR);

   if (NCH < 1 || NEP < 1) begin : g_bad_src
      $error("source vectors must be non-empty");
   end

   logic sts_hit, wr_hit, rd_hit, mismatch;
   assign sts_hit = bus_sel_i && (bus_addr_i == STS_A);
   assign wr_hit  = sts_hit && bus_wr_i;
   assign rd_hit  = sts_hit && !bus_wr_i;

   dri_mode_guard #(
      .AW(AW), .STS_ADDR(STS_ADDR), .HOST_LO(HOST_LO), .HOST_HI(HOST_HI),
      .DEV_LO(DEV_LO), .DEV_HI(DEV_HI)
   ) u_guard (
      .host_mode_i (host_mode_i),
      .sel_i       (bus_sel_i),
      .addr_i      (bus_addr_i),
      .mismatch_o  (mismatch)
   );

   logic [SW-1:0] frame_ok, latch_set, latch_clr, latch_q;
   assign frame_ok  = eopf_i ? '1 : ~FRAME_GATED;
   assign latch_set = (evt_i & frame_ok & ~(SW'(1) << B_MISMATCH)) | (SW'(mismatch) << B_MISMATCH);
   assign latch_clr = wr_hit ? bus_wdata_i : '0;

   dri_latch_bank #(.KEEP_MASK(LATCH_BITS), .RST_VAL(LATCH_RST)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (latch_set),
      .clr_i (latch_clr),
      .q_o   (latch_q)
   );

   logic rx_lvl, ptx_empty, nak_out, nak_in;
   dri_level_track #(.PTX_DEPTH(PTX_DEPTH), .PQ_W(PQ_W), .FREE_W(FREE_W)) u_level (
      .clk            (clk),
      .rst_n          (rst_n),
      .rx_nonempty_i  (rx_nonempty_i),
      .ptx_free_i     (ptx_free_i),
      .ptx_full_sel_i (ptx_full_sel_i),
      .pq_space_i     (pq_space_i),
      .nak_out_set_i  (nak_out_set_i),
      .nak_out_clr_i  (nak_out_clr_i),
      .nak_in_set_i   (nak_in_set_i),
      .nak_in_clr_i   (nak_in_clr_i),
      .rx_lvl_o       (rx_lvl),
      .ptx_empty_o    (ptx_empty),
      .nak_out_o      (nak_out),
      .nak_in_o       (nak_in)
   );

   logic [SW-1:0] live_bits, raw_word, role_hide, view;
   always_comb begin
      live_bits = '0;
      live_bits[0]         = host_mode_i;
      live_bits[B_OTG]     = otg_src_i;
      live_bits[B_RXLVL]   = rx_lvl;
      live_bits[B_INNAK]   = nak_in;
      live_bits[B_OUTNAK]  = nak_out;
      live_bits[B_IEP]     = |iep_src_i;
      live_bits[B_OEP]     = |oep_src_i;
      live_bits[B_PORT]    = port_src_i;
      live_bits[B_HCH]     = |hch_src_i;
      live_bits[B_PTXE]    = ptx_empty;
   end

   assign raw_word    = latch_q | live_bits;
   assign role_hide   = host_mode_i ? DEV_ONLY : HOST_ONLY;
   assign view        = raw_word & ~role_hide & ~RSV_BITS;
   assign bus_rdata_o = rd_hit ? view : '0;
   assign irq_o       = |(view & irq_mask_i);

   // R9: a wrong-role access shows up as the mismatch flag next cycle
   a_r9_mismatch_flag: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |=> view[B_MISMATCH]);
   // R9: accessing the status word itself never raises the flag
   a_r9_sts_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_hit && !view[B_MISMATCH] && !evt_i[B_MISMATCH]) |=> !view[B_MISMATCH]);
endmodule

// File: tb/dualrole_irq_status_tb.sv
module dualrole_irq_status_tb;
   localparam int AW = 10, STS = 5, NCH = 4, NEP = 3, DEPTH = 16, PQW = 2;
   localparam int FW = $clog2(DEPTH + 1);

   logic clk = 0, rst_n = 0, host_mode = 1;
   logic bus_sel = 0, bus_wr = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, rdata, evt = '0, mask = '0;
   logic eopf = 0, rx_ne = 0, full_sel = 0, port_src = 0, otg_src = 0;
   logic [FW-1:0] ptx_free = FW'(DEPTH);
   logic [PQW-1:0] pq_space = 1;
   logic [NCH-1:0] hch = '0;
   logic [NEP-1:0] iep = '0, oep = '0;
   logic no_set = 0, no_clr = 0, ni_set = 0, ni_clr = 0, irq;

   always #2 clk = ~clk;

   dualrole_irq_status #(
      .AW(AW), .STS_ADDR(STS), .HOST_LO(256), .HOST_HI(383), .DEV_LO(512), .DEV_HI(767),
      .NCH(NCH), .NEP(NEP), .PTX_DEPTH(DEPTH), .PQ_W(PQW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .host_mode_i(host_mode),
      .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata),
      .evt_i(evt), .eopf_i(eopf), .rx_nonempty_i(rx_ne),
      .ptx_free_i(ptx_free), .ptx_full_sel_i(full_sel), .pq_space_i(pq_space),
      .hch_src_i(hch), .port_src_i(port_src), .iep_src_i(iep), .oep_src_i(oep),
      .otg_src_i(otg_src), .nak_out_set_i(no_set), .nak_out_clr_i(no_clr),
      .nak_in_set_i(ni_set), .nak_in_clr_i(ni_clr), .irq_mask_i(mask), .irq_o(irq)
   );

   typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
   item_t sbq[$];
   int n_chk = 0, n_fail = 0;
   logic probe = 0;
   bit done = 0;

   // monitor: pops one expected item per probe cycle
   always @(negedge clk) begin
      if (probe && sbq.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sbq.pop_front();
         act = it.is_irq ? {31'b0, irq} : rdata;
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic rd(input logic [31:0] exp, input string tag);
      item_t it;
      it.is_irq = 0; it.exp = exp; it.tag = tag;
      @(posedge clk); #1;
      bus_sel = 1; bus_wr = 0; bus_addr = AW'(STS); probe = 1;
      sbq.push_back(it);
      @(posedge clk); #1;
      bus_sel = 0; probe = 0;
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      item_t it;
      it.is_irq = 1; it.exp = {31'b0, exp}; it.tag = tag;
      @(posedge clk); #1;
      probe = 1;
      sbq.push_back(it);
      @(posedge clk); #1;
      probe = 0;
   endtask

   task automatic wr(input logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = 1; bus_wr = 1; bus_addr = AW'(STS); bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic touch(input int a, input logic w);
      @(posedge clk); #1;
      bus_sel = 1; bus_wr = w; bus_addr = AW'(a); bus_wdata = '1;
      @(posedge clk); #1;
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic pulse(input logic [31:0] e, input logic frame);
      @(posedge clk); #1;
      evt = e; eopf = frame;
      @(posedge clk); #1;
      evt = '0; eopf = 0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      rd(32'h1400_0001, "R1 during reset");
      #1 rst_n = 1;
      rd(32'h1400_0001, "R1 after reset");
      host_mode = 0;
      rd(32'h1000_0000, "R2 device role");
      host_mode = 1;
      wr(32'h1000_0000);
      rd(32'h0400_0001, "R3 clear id change");
      // R3 set and hold
      pulse(32'h8000_0008, 0);
      rd(32'h8400_0009, "R3 set");
      wr(32'h0);
      rd(32'h8400_0009, "R3 write zero");
      wr(32'h0000_0008);
      rd(32'h8400_0001, "R3 clear one");
      wr(32'h8000_0000);
      // R4 collision
      @(posedge clk); #1;
      evt = 32'h4000_0000; bus_sel = 1; bus_wr = 1; bus_addr = AW'(STS); bus_wdata = 32'h4000_0000;
      @(posedge clk); #1;
      evt = '0; bus_sel = 0; bus_wr = 0;
      rd(32'h4400_0001, "R4 set wins");
      wr(32'h4000_0000);
      rd(32'h0400_0001, "R4 then cleared");
      // R5 frame gating
      host_mode = 0;
      pulse(32'h0030_0000, 0);
      rd(32'h0000_0000, "R5 no frame");
      pulse(32'h0030_0000, 1);
      rd(32'h0030_0000, "R5 with frame");
      wr(32'h0030_0000);
      // R6 summaries
      host_mode = 1; hch = 4'b0100; port_src = 1; otg_src = 1;
      rd(32'h0700_0005, "R6 host summaries");
      wr(32'hFFFF_FFFF);
      rd(32'h0700_0005, "R6 not writable");
      hch = '0; port_src = 0; otg_src = 0;
      rd(32'h0400_0001, "R6 sources cleared");
      host_mode = 0; iep = 3'b010; oep = 3'b001;
      rd(32'h000C_0000, "R6 endpoint summaries");
      iep = '0; oep = '0;
      // R10 role hiding
      hch = 4'b0001;
      rd(32'h0000_0000, "R10 host bit hidden");
      host_mode = 1; hch = '0; iep = 3'b100;
      rd(32'h0400_0001, "R10 device bit hidden");
      iep = '0;
      // R7 receive level
      rx_ne = 1;
      rd(32'h0400_0011, "R7 rx pending");
      rx_ne = 0;
      rd(32'h0400_0001, "R7 rx drained");
      // R8 periodic threshold
      ptx_free = 8;
      rd(32'h0400_0001, "R8 half at 8");
      ptx_free = 7;
      rd(32'h0000_0001, "R8 below half");
      full_sel = 1; ptx_free = 15;
      rd(32'h0000_0001, "R8 full sel 15");
      ptx_free = 16;
      rd(32'h0400_0001, "R8 full sel 16");
      pq_space = 0;
      rd(32'h0000_0001, "R8 queue full");
      pq_space = 1; full_sel = 0;
      rd(32'h0400_0001, "R8 restored");
      // R9 mismatch
      host_mode = 0;
      touch(300, 0);
      rd(32'h0000_0002, "R9 host window in device role");
      wr(32'h2);
      rd(32'h0000_0000, "R9 cleared");
      host_mode = 1;
      touch(600, 1);
      rd(32'h0400_0003, "R9 device window in host role");
      wr(32'h2);
      touch(300, 1);
      rd(32'h0400_0001, "R9 own window no flag");
      // R11 NAK flags
      host_mode = 0;
      @(posedge clk); #1 no_set = 1; @(posedge clk); #1 no_set = 0;
      rd(32'h0000_0080, "R11 out nak set");
      wr(32'h0000_0080);
      rd(32'h0000_0080, "R11 write ignored");
      @(posedge clk); #1 no_clr = 1; @(posedge clk); #1 no_clr = 0;
      rd(32'h0000_0000, "R11 out nak cleared");
      @(posedge clk); #1 ni_set = 1; @(posedge clk); #1 ni_set = 0;
      rd(32'h0000_0040, "R11 in nak set");
      @(posedge clk); #1 ni_clr = 1; @(posedge clk); #1 ni_clr = 0;
      rd(32'h0000_0000, "R11 in nak cleared");
      // R12 masked interrupt
      host_mode = 1;
      touch(600, 0);
      mask = 32'h0000_0002;
      chk_irq(1'b1, "R12 mismatch enabled");
      mask = 32'h0000_0008;
      chk_irq(1'b0, "R12 sof not pending");
      host_mode = 0; mask = 32'h0400_0000;
      chk_irq(1'b0, "R12 hidden bit masked in");
      host_mode = 1;
      chk_irq(1'b1, "R12 ptx empty enabled");
      repeat (2) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule